// File: doc/BRIEF.md
# Amplifier control and status serial slave

This block is the serial-bus front end of a dual-channel power amplifier. It listens on a two-wire I2C bus as a slave and holds two instruction bytes. Those bytes select standby, play or mute, gain, clip-detect threshold, diagnostic and offset-check enables, the high-efficiency output mode and the line-driver diagnostic mode. A read returns a two-byte status word built from fault flags that the analog side provides. Each completed read also emits a one-clock re-arm pulse, which tells the diagnostic engines to start new measurement cycles. The data just read therefore always comes from the cycle before.

Two strap inputs set the low two bits of the slave address, so four amplifiers can share one bus. A bus-enable input chooses who controls the amplifier. When it is high, the bus registers set the modes. When it is low, the bus is ignored and three discrete pins set standby, high-efficiency and play directly. The standby pin can always force the amplifier into standby, whichever mode is in use. Both bus lines are oversampled by the block clock, and SDA is driven open-drain through an output-enable.

Top module: `amp_ctl_i2c_slave`

## Requirements
- R1: The slave address is 1,1,0,1,0,strap_b,strap_a, MSB first, and is followed by the R/W bit (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low on the ninth clock. A mismatched address gets no acknowledge, and every byte up to the next START is ignored.
- R2: A write transfer stores its first data byte as IB1 and its second as IB2. Each of these two bytes is acknowledged.
- R3: IB1 fields drive these outputs: bit6 `diag_en`, bit5 `ofs_en`, bit4 `gain_low` (1 = low gain), bit2 unmute (1 = play), bit0 `clip_hi` (1 = higher clip threshold). Bits 7, 3 and 1 have no effect.
- R4: IB2 fields drive these outputs: bit4 standby-off (1 = `amp_active`), bit3 `line_diag`, bit1 `hi_eff`. Bits 7, 6, 5, 2 and 0 have no effect.
- R5: Write bytes after IB2 are not acknowledged and leave both registers unchanged.
- R6: A read returns two status bytes, MSB first, each followed by a master acknowledge bit.
  - First byte: {therm_warn, diag_done, 0, ch1_flags[4:0]}.
  - Second byte: {ofs_active, 0, 0, ch2_flags[4:0]}.
  - The values are captured when the read address is acknowledged, so flags that change later in the transfer do not appear.
- R7: A STOP that ends a read transfer produces exactly one `rearm` pulse, one clock long. A write transfer produces none.
- R8: When `bus_en` is low, the slave never drives SDA and the instruction registers keep their values. In this mode `amp_active` follows `pin_stby`, `hi_eff` follows `pin_hieff` and `play` follows `pin_mute`. The bus-only outputs (`gain_low`, `clip_hi`, `diag_en`, `ofs_en`, `line_diag`) are low.
- R9: `pin_stby` low forces `amp_active` low, and `pin_mute` low forces `play` low, in both control modes.
- R10: After reset both registers are zero: the amplifier is in standby and muted at high gain with every enable off, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| strap_a | input | 1 | Address bit 0 strap |
| strap_b | input | 1 | Address bit 1 strap |
| bus_en | input | 1 | 1 = bus control, 0 = discrete-pin control |
| pin_stby | input | 1 | Standby pin, 0 = standby |
| pin_hieff | input | 1 | Discrete high-efficiency select |
| pin_mute | input | 1 | Mute pin, 0 = mute |
| therm_warn | input | 1 | Thermal warning flag |
| diag_done | input | 1 | Diagnostic cycle finished flag |
| ofs_active | input | 1 | Offset check running flag |
| ch1_flags | input | 5 | Channel 1 fault flags |
| ch2_flags | input | 5 | Channel 2 fault flags |
| amp_active | output | 1 | Amplifier out of standby |
| play | output | 1 | Amplifier unmuted |
| gain_low | output | 1 | Low gain selected |
| clip_hi | output | 1 | Higher clip threshold selected |
| diag_en | output | 1 | Diagnostics enabled |
| ofs_en | output | 1 | Offset detection enabled |
| hi_eff | output | 1 | High-efficiency output mode |
| line_diag | output | 1 | Line-driver diagnostic thresholds |
| rearm | output | 1 | One-clock diagnostic re-arm pulse |

## Verification
The assertions run on every cycle and cover four things. They check that the standby and mute pins always override the bus, and that with the bus disabled the bus-only outputs are low, SDA stays released and both instruction registers hold. They also check that `rearm` never lasts longer than one clock. Other behaviour needs whole bus transfers, so only the directed scenarios can show it:

- address matching against the straps and the ignoring of a mismatched address;
- how each field maps onto its output;
- the refusal of a third write byte;
- the capture of status at the address acknowledge;
- the presence or absence of the re-arm pulse after reads and after writes.

// File: rtl/amp_ctl_i2c_slave.sv
module amp_ctl_i2c_slave #(
  parameter logic [4:0] ADDR_HI     = 5'b11010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_a,
  input  logic       strap_b,
  input  logic       bus_en,
  input  logic       pin_stby,
  input  logic       pin_hieff,
  input  logic       pin_mute,
  input  logic       therm_warn,
  input  logic       diag_done,
  input  logic       ofs_active,
  input  logic [4:0] ch1_flags,
  input  logic [4:0] ch2_flags,
  output logic       amp_active,
  output logic       play,
  output logic       gain_low,
  output logic       clip_hi,
  output logic       diag_en,
  output logic       ofs_en,
  output logic       hi_eff,
  output logic       line_diag,
  output logic       rearm
);

  localparam int SW = SYNC_STAGES + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK, S_SKIP
  } st_t;

  logic [SW-1:0] scl_q, sda_q;
  st_t           st;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [1:0]    idx;
  logic          rw, rd_act;
  logic [15:0]   snap;
  logic [7:0]    ib1, ib2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SW-2:0], scl_i};
      sda_q <= {sda_q[SW-2:0], sda_i};
    end
  end

  wire scl_now   = scl_q[SW-2];
  wire scl_old   = scl_q[SW-1];
  wire sda_now   = sda_q[SW-2];
  wire sda_old   = sda_q[SW-1];
  wire scl_rise  = scl_now & ~scl_old;
  wire scl_fall  = ~scl_now & scl_old;
  wire bus_start = scl_now & scl_old & sda_old & ~sda_now;
  wire bus_stop  = scl_now & scl_old & ~sda_old & sda_now;

  wire [6:0]  my_addr = {ADDR_HI, strap_b, strap_a};
  wire [15:0] diag_w  = {therm_warn, diag_done, 1'b0, ch1_flags,
                         ofs_active, 2'b00, ch2_flags};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      idx    <= '0;
      rw     <= 1'b0;
      rd_act <= 1'b0;
      snap   <= '0;
      ib1    <= '0;
      ib2    <= '0;
      sda_oe <= 1'b0;
      rearm  <= 1'b0;
    end else begin
      rearm <= 1'b0;
      if (!bus_en) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        rd_act <= 1'b0;
      end else if (bus_start) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (bus_stop) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        rearm  <= rd_act;
        rd_act <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_now};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == my_addr) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                st     <= S_AACK;
                if (sh[0]) snap <= diag_w;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              idx <= '0;
              if (rw) begin
                st     <= S_RD;
                sh     <= snap[15:8];
                sda_oe <= ~snap[15];
                rd_act <= 1'b1;
              end else begin
                st     <= S_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_now};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              st <= S_WACK;
              if (idx == 2'd0) begin
                ib1    <= sh;
                sda_oe <= 1'b1;
              end else if (idx == 2'd1) begin
                ib2    <= sh;
                sda_oe <= 1'b1;
              end
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_WR;
              if (idx != 2'd2) idx <= idx + 2'd1;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                sh     <= {sh[6:0], 1'b1};
                sda_oe <= ~sh[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise && sda_now) begin
              st <= S_SKIP;
            end else if (scl_fall) begin
              cnt <= '0;
              st  <= S_RD;
              if (idx != 2'd2) idx <= idx + 2'd1;
              if (idx == 2'd0) begin
                sh     <= snap[7:0];
                sda_oe <= ~snap[7];
              end else begin
                sh     <= 8'hFF;
                sda_oe <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign amp_active = pin_stby & (~bus_en | ib2[4]);
  assign hi_eff     = bus_en ? ib2[1] : pin_hieff;
  assign play       = pin_mute & (~bus_en | ib1[2]);
  assign gain_low   = bus_en & ib1[4];
  assign clip_hi    = bus_en & ib1[0];
  assign diag_en    = bus_en & ib1[6];
  assign ofs_en     = bus_en & ib1[5];
  assign line_diag  = bus_en & ib2[3];

endmodule

// File: rtl/amp_ctl_i2c_slave_chk.sv
module amp_ctl_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       pin_stby,
  input logic       pin_mute,
  input logic       sda_oe,
  input logic       rearm,
  input logic       amp_active,
  input logic       play,
  input logic       gain_low,
  input logic       clip_hi,
  input logic       diag_en,
  input logic       ofs_en,
  input logic       line_diag,
  input logic [7:0] ib1,
  input logic [7:0] ib2
);

  // R8
  sda_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !sda_oe);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> ($stable(ib1) && $stable(ib2)));

  // R8
  pin_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> !(gain_low | clip_hi | diag_en | ofs_en | line_diag));

  // R9
  stby_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_stby |-> !amp_active);

  // R9
  mute_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_mute |-> !play);

  // R7
  rearm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !rearm);

  // R7
  rearm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |-> !sda_oe);

endmodule

bind amp_ctl_i2c_slave amp_ctl_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .pin_stby(pin_stby),
  .pin_mute(pin_mute), .sda_oe(sda_oe), .rearm(rearm),
  .amp_active(amp_active), .play(play), .gain_low(gain_low),
  .clip_hi(clip_hi), .diag_en(diag_en), .ofs_en(ofs_en),
  .line_diag(line_diag), .ib1(ib1), .ib2(ib2)
);

// File: tb/sim_amp_ctl_i2c_slave.sv
`timescale 1ns/1ps
module sim_amp_ctl_i2c_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic strap_a = 1'b1, strap_b = 1'b0;
  logic bus_en = 1'b1, pin_stby = 1'b1, pin_hieff = 1'b0, pin_mute = 1'b1;
  logic therm_warn = 1'b0, diag_done = 1'b0, ofs_active = 1'b0;
  logic [4:0] ch1_flags = '0, ch2_flags = '0;
  logic sda_oe, amp_active, play, gain_low, clip_hi, diag_en, ofs_en;
  logic hi_eff, line_diag, rearm;
  wire  sda_line = m_sda & ~sda_oe;

  int n_run = 0, n_fail = 0, n_rearm = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  amp_ctl_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a(strap_a), .strap_b(strap_b), .bus_en(bus_en),
    .pin_stby(pin_stby), .pin_hieff(pin_hieff), .pin_mute(pin_mute),
    .therm_warn(therm_warn), .diag_done(diag_done), .ofs_active(ofs_active),
    .ch1_flags(ch1_flags), .ch2_flags(ch2_flags),
    .amp_active(amp_active), .play(play), .gain_low(gain_low),
    .clip_hi(clip_hi), .diag_en(diag_en), .ofs_en(ofs_en),
    .hi_eff(hi_eff), .line_diag(line_diag), .rearm(rearm)
  );

  always @(negedge clk) if (rearm) n_rearm++;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; m_scl = 1'b1; half();
    m_sda = 1'b0; half();
    m_scl = 1'b0; half();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; half();
    m_scl = 1'b1; half();
    m_sda = 1'b1; half(); half();
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    m_sda = b; half();
    m_scl = 1'b1; half();
    seen = sda_line; half();
    m_scl = 1'b0; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] b1, input logic [7:0] b2,
                          output logic k0, output logic k1, output logic k2);
    i2c_start();
    send_byte({a, 1'b0}, k0);
    send_byte(b1, k1);
    send_byte(b2, k2);
    i2c_stop();
  endtask

  task automatic t_reset();
    check("R10 sda released", sda_oe, 0);
    check("R10 amp_active", amp_active, 0);
    check("R10 play", play, 0);
    check("R10 bus fields", {gain_low, clip_hi, diag_en, ofs_en, line_diag, hi_eff}, 0);
    check("R10 rearm", rearm, 0);
  endtask

  task automatic t_fields();
    logic k0, k1, k2;
    do_write(7'h69, 8'h75, 8'h1A, k0, k1, k2);
    check("R1 address ack", k0, 1);
    check("R2 IB1 ack", k1, 1);
    check("R2 IB2 ack", k2, 1);
    check("R3 IB1 fields set", {diag_en, ofs_en, gain_low, play, clip_hi}, 5'b11111);
    check("R4 IB2 fields set", {amp_active, line_diag, hi_eff}, 3'b111);
    do_write(7'h69, 8'h8A, 8'h65, k0, k1, k2);
    check("R3 IB1 unused bits", {diag_en, ofs_en, gain_low, play, clip_hi}, 0);
    check("R4 IB2 unused bits", {amp_active, line_diag, hi_eff}, 0);
  endtask

  task automatic t_extra();
    logic k0, k1, k2, k3;
    int r0;
    r0 = n_rearm;
    i2c_start();
    send_byte({7'h69, 1'b0}, k0);
    send_byte(8'h40, k1);
    send_byte(8'h10, k2);
    send_byte(8'hFF, k3);
    i2c_stop();
    check("R5 third byte nack", k3, 0);
    check("R5 IB1 kept", {diag_en, ofs_en, gain_low, play, clip_hi}, 5'b10000);
    check("R5 IB2 kept", {amp_active, line_diag, hi_eff}, 3'b100);
    check("R7 no rearm after write", n_rearm - r0, 0);
  endtask

  task automatic t_read();
    logic k0;
    logic [7:0] d1, d2;
    int r0;
    therm_warn = 1'b1; diag_done = 1'b0; ofs_active = 1'b1;
    ch1_flags = 5'b01010; ch2_flags = 5'b10101;
    r0 = n_rearm;
    i2c_start();
    send_byte({7'h69, 1'b1}, k0);
    therm_warn = 1'b0; diag_done = 1'b1; ofs_active = 1'b0;
    ch1_flags = 5'b10001; ch2_flags = 5'b01100;
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    i2c_stop();
    check("R1 read address ack", k0, 1);
    check("R6 DB1 snapshot", d1, 8'h8A);
    check("R6 DB2 snapshot", d2, 8'h95);
    check("R7 one rearm after read", n_rearm - r0, 1);
    r0 = n_rearm;
    i2c_start();
    send_byte({7'h69, 1'b1}, k0);
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    i2c_stop();
    check("R6 DB1 new", d1, 8'h51);
    check("R6 DB2 new", d2, 8'h0C);
    check("R7 second rearm", n_rearm - r0, 1);
  endtask

  task automatic t_nomatch();
    logic k0, k1, k2;
    do_write(7'h6B, 8'h75, 8'h1A, k0, k1, k2);
    check("R1 mismatch nack", k0, 0);
    check("R1 mismatch data ignored", {k1, k2}, 0);
    check("R1 mismatch regs kept", {diag_en, play, amp_active, hi_eff}, 4'b1010);
    strap_b = 1'b1; strap_a = 1'b0;
    repeat (4) @(negedge clk);
    do_write(7'h6A, 8'h51, 8'h12, k0, k1, k2);
    check("R1 new strap ack", k0, 1);
    check("R1 new strap write", {diag_en, gain_low, clip_hi, amp_active, hi_eff}, 5'b11111);
  endtask

  task automatic t_pins();
    logic k0, k1, k2;
    int r0;
    bus_en = 1'b0; pin_stby = 1'b1; pin_hieff = 1'b1; pin_mute = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 pins drive modes", {amp_active, hi_eff, play}, 3'b111);
    check("R8 bus fields off", {gain_low, clip_hi, diag_en, ofs_en, line_diag}, 0);
    pin_hieff = 1'b0; pin_mute = 1'b0;
    #1;
    check("R8 pins follow", {amp_active, hi_eff, play}, 3'b100);
    r0 = n_rearm;
    do_write(7'h6A, 8'h00, 8'h08, k0, k1, k2);
    check("R8 no ack when disabled", {k0, k1, k2}, 0);
    i2c_start();
    send_byte({7'h6A, 1'b1}, k0);
    i2c_stop();
    check("R8 no read ack, no rearm", {k0, 1'(n_rearm - r0)}, 0);
    bus_en = 1'b1; pin_mute = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 regs kept while disabled", {diag_en, gain_low, clip_hi, amp_active, hi_eff, line_diag}, 6'b111110);
  endtask

  task automatic t_stby();
    logic k0, k1, k2;
    do_write(7'h6A, 8'h04, 8'h10, k0, k1, k2);
    check("R9 playing", {amp_active, play}, 2'b11);
    pin_stby = 1'b0;
    #1;
    check("R9 stby pin forces standby", amp_active, 0);
    pin_stby = 1'b1; pin_mute = 1'b0;
    #1;
    check("R9 mute pin forces mute", {amp_active, play}, 2'b10);
    bus_en = 1'b0; pin_stby = 1'b0; pin_mute = 1'b1;
    #1;
    check("R9 stby pin in pin mode", {amp_active, play}, 2'b01);
    bus_en = 1'b1; pin_stby = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fields();
    t_extra();
    t_read();
    t_nomatch();
    t_pins();
    t_stby();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule